// File: doc/BRIEF.md
# Tagged Out-of-Order Memory Request Tracker

This block stands between an accelerator and a memory system that may have several accesses pending at once and may answer them in any order. Each load or store that the client offers is given a tag from a small pool, the purpose of the request is recorded in a per-tag table, and the request goes on to memory over a valid/ready channel. The request fields pass through combinationally, so issue costs no extra cycle.

Memory answers on a channel that has a valid signal but no ready, so the block accepts a response in any cycle one appears. The returned tag selects the table entry. The entry is retired, its tag is freed, and a completion goes to the client one cycle later. The completion carries the client's own slot index, a load/store flag and the load data. A response whose tag is not in use sets a sticky error flag and changes nothing else.

Top module: `mem_tag_tracker`

## Requirements
- R1: After reset no tag is in use, `cl_done_valid` and `tag_err` are 0, and `cl_req_ready` equals `mem_req_ready`.
- R2: While all `TAGS` tags are in use, `mem_req_valid` and `cl_req_ready` are both 0, whatever the client and memory drive.
- R3: When at least one tag is free, `mem_req_valid` equals `cl_req_valid` in the same cycle. `mem_req_tag` is the lowest-numbered free tag. Address, size, write data and the store bit (1 = store, 0 = load) equal the client's inputs in that same cycle.
- R4: A tag becomes in use only on a cycle where `mem_req_valid` and `mem_req_ready` are both 1. If `mem_req_ready` is 0, the same tag is offered again on the next cycle.
- R5: A response whose tag is in use produces, on the next cycle only, `cl_done_valid`=1 with the slot index and store bit recorded at issue. `cl_done_data` is the response data for a load and zero for a store. The tag is free from that next cycle on.
- R6: Responses may arrive in any order relative to issue, and each one completes with the slot of its own request.
- R7: When a response frees a tag in the same cycle that a request is issued, both take effect. The freed tag is not offered in that cycle but can be allocated from the next cycle.
- R8: A response whose tag is not in use sets `tag_err`, which stays 1 until reset. That response produces no completion and leaves the table unchanged.
- R9: Up to `TAGS` requests can be in flight at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cl_req_valid | input | 1 | Client offers a request |
| cl_req_ready | output | 1 | Request taken this cycle if valid |
| cl_req_addr | input | ADDR_W | Request address |
| cl_req_store | input | 1 | 1 = store, 0 = load |
| cl_req_size | input | SIZE_W | Access size code |
| cl_req_wdata | input | DATA_W | Store data |
| cl_req_slot | input | SLOT_W | Client slot index echoed at completion |
| mem_req_valid | output | 1 | Request to memory valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Address to memory |
| mem_req_tag | output | TAG_W | Allocated tag |
| mem_req_store | output | 1 | 1 = store, 0 = load |
| mem_req_size | output | SIZE_W | Size code to memory |
| mem_req_wdata | output | DATA_W | Store data to memory |
| mem_rsp_valid | input | 1 | Response present (cannot be stalled) |
| mem_rsp_tag | input | TAG_W | Tag of the response |
| mem_rsp_data | input | DATA_W | Response data |
| cl_done_valid | output | 1 | Completion to client |
| cl_done_slot | output | SLOT_W | Slot of the completed request |
| cl_done_store | output | 1 | Completed request was a store |
| cl_done_data | output | DATA_W | Load data, zero for stores |
| tag_err | output | 1 | Sticky: a response named a tag that was not in use |

## Verification
The bench fills every tag and then holds memory back, so a design that miscounts in-flight entries would show up as an extra issue or an unneeded stall. It frees a tag in the same cycle that another is allocated, which catches a design that offers the just-freed tag too early or drops one of the two updates. It stalls `mem_req_ready` while a request is pending, which catches allocation without a handshake: the next cycle would then offer a different tag. It also returns responses in scrambled order and sends responses for idle tags, so swapped slots, double retirement or a non-sticky error flag show up at the completion and error outputs.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

    localparam int SLOT_W = 5;

    typedef enum logic {
        CMD_LOAD  = 1'b0,
        CMD_STORE = 1'b1
    } mem_cmd_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        mem_cmd_e          cmd;
    } track_ent_t;

endpackage

// File: rtl/mtt_tag_alloc.sv
module mtt_tag_alloc #(
    parameter int TAGS  = 4,
    parameter int TAG_W = (TAGS > 1) ? $clog2(TAGS) : 1
) (
    input  logic [TAGS-1:0]  busy_map,
    output logic             any_free,
    output logic [TAG_W-1:0] free_idx
);
    // Scan from the top down so the lowest free index wins.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (!busy_map[i]) begin
                any_free = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end
endmodule

// File: rtl/mtt_table.sv
module mtt_table
    import mtt_pkg::*;
#(
    parameter int TAGS  = 4,
    parameter int TAG_W = (TAGS > 1) ? $clog2(TAGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_idx,
    input  track_ent_t       alloc_ent,
    input  logic             free_en,
    input  logic [TAG_W-1:0] look_idx,
    output logic [TAGS-1:0]  busy_map,
    output track_ent_t       look_ent
);
    track_ent_t ents [TAGS];

    for (genvar g = 0; g < TAGS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                busy_map[g] <= 1'b0;
                ents[g]     <= '0;
            end else if (alloc_en && alloc_idx == TAG_W'(g)) begin
                busy_map[g] <= 1'b1;
                ents[g]     <= alloc_ent;
            end else if (free_en && look_idx == TAG_W'(g)) begin
                busy_map[g] <= 1'b0;
            end
        end
    end

    assign look_ent = ents[look_idx];

    // R4: a handshake marks its tag in use
    p_alloc_marks_r4: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> busy_map[$past(alloc_idx)]);

    // R5: a matched response releases its tag
    p_free_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (free_en && !(alloc_en && alloc_idx == look_idx)) |=> !busy_map[$past(look_idx)]);

    // R4: without allocation or release the map holds
    p_map_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!alloc_en && !free_en) |=> $stable(busy_map));
endmodule

// File: rtl/mem_tag_tracker.sv
module mem_tag_tracker
    import mtt_pkg::*;
#(
    parameter int TAGS   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 3,
    localparam int TAG_W = (TAGS > 1) ? $clog2(TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cl_req_valid,
    output logic              cl_req_ready,
    input  logic [ADDR_W-1:0] cl_req_addr,
    input  logic              cl_req_store,
    input  logic [SIZE_W-1:0] cl_req_size,
    input  logic [DATA_W-1:0] cl_req_wdata,
    input  logic [SLOT_W-1:0] cl_req_slot,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    output logic              mem_req_store,
    output logic [SIZE_W-1:0] mem_req_size,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              cl_done_valid,
    output logic [SLOT_W-1:0] cl_done_slot,
    output logic              cl_done_store,
    output logic [DATA_W-1:0] cl_done_data,
    output logic              tag_err
);
    logic [TAGS-1:0]  busy_map;
    logic             any_free;
    logic [TAG_W-1:0] free_idx;
    logic             issue_fire;
    logic             rsp_hit;
    logic             rsp_miss;
    track_ent_t       new_ent;
    track_ent_t       hit_ent;

    mtt_tag_alloc #(.TAGS(TAGS), .TAG_W(TAG_W)) u_alloc (
        .busy_map (busy_map),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    assign new_ent.slot = cl_req_slot;
    assign new_ent.cmd  = cl_req_store ? CMD_STORE : CMD_LOAD;

    mtt_table #(.TAGS(TAGS), .TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (issue_fire),
        .alloc_idx (free_idx),
        .alloc_ent (new_ent),
        .free_en   (rsp_hit),
        .look_idx  (mem_rsp_tag),
        .busy_map  (busy_map),
        .look_ent  (hit_ent)
    );

    // Request path: combinational pass-through gated by tag availability.
    assign mem_req_valid = cl_req_valid && any_free;
    assign cl_req_ready  = mem_req_ready && any_free;
    assign mem_req_addr  = cl_req_addr;
    assign mem_req_tag   = free_idx;
    assign mem_req_store = cl_req_store;
    assign mem_req_size  = cl_req_size;
    assign mem_req_wdata = cl_req_wdata;
    assign issue_fire    = mem_req_valid && mem_req_ready;

    // Response path: always accepted, matched against the table.
    assign rsp_hit  = mem_rsp_valid && busy_map[mem_rsp_tag];
    assign rsp_miss = mem_rsp_valid && !busy_map[mem_rsp_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            cl_done_valid <= 1'b0;
            cl_done_slot  <= '0;
            cl_done_store <= 1'b0;
            cl_done_data  <= '0;
            tag_err       <= 1'b0;
        end else begin
            cl_done_valid <= rsp_hit;
            if (rsp_hit) begin
                cl_done_slot  <= hit_ent.slot;
                cl_done_store <= (hit_ent.cmd == CMD_STORE);
                cl_done_data  <= (hit_ent.cmd == CMD_STORE) ? '0 : mem_rsp_data;
            end
            if (rsp_miss) tag_err <= 1'b1;
        end
    end

    // R2: nothing issues while every tag is taken
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(busy_map) == TAGS) |-> (!mem_req_valid && !cl_req_ready));

    // R3: the offered tag is never one already in flight
    p_tag_free_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !busy_map[mem_req_tag]);

    // R5: a completion always follows a response
    p_done_after_rsp_r5: assert property (@(posedge clk) disable iff (rst)
        cl_done_valid |-> $past(mem_rsp_valid));

    // R8: the error flag never clears outside reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        tag_err |=> tag_err);

    // R8: a stray response yields no completion
    p_miss_no_done_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |=> !cl_done_valid);
endmodule

// File: tb/mem_tag_tracker_tb.sv
module mem_tag_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TAGS   = 4;
    localparam int TAG_W  = 2;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int SIZE_W = 3;
    localparam int SLOT_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cl_req_valid = 1'b0;
    logic              cl_req_ready;
    logic [ADDR_W-1:0] cl_req_addr = '0;
    logic              cl_req_store = 1'b0;
    logic [SIZE_W-1:0] cl_req_size = '0;
    logic [DATA_W-1:0] cl_req_wdata = '0;
    logic [SLOT_W-1:0] cl_req_slot = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [TAG_W-1:0]  mem_req_tag;
    logic              mem_req_store;
    logic [SIZE_W-1:0] mem_req_size;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [TAG_W-1:0]  mem_rsp_tag = '0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic              cl_done_valid;
    logic [SLOT_W-1:0] cl_done_slot;
    logic              cl_done_store;
    logic [DATA_W-1:0] cl_done_data;
    logic              tag_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_tag_tracker #(.TAGS(TAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst(rst),
        .cl_req_valid(cl_req_valid), .cl_req_ready(cl_req_ready),
        .cl_req_addr(cl_req_addr), .cl_req_store(cl_req_store),
        .cl_req_size(cl_req_size), .cl_req_wdata(cl_req_wdata), .cl_req_slot(cl_req_slot),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_req_store(mem_req_store), .mem_req_size(mem_req_size),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
        .cl_done_valid(cl_done_valid), .cl_done_slot(cl_done_slot),
        .cl_done_store(cl_done_store), .cl_done_data(cl_done_data),
        .tag_err(tag_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model
    bit              m_busy  [TAGS];
    bit [SLOT_W-1:0] m_slot  [TAGS];
    bit              m_store [TAGS];
    bit              e_dv = 1'b0;
    bit [SLOT_W-1:0] e_slot = '0;
    bit              e_st = 1'b0;
    bit [DATA_W-1:0] e_data = '0;
    bit              e_err = 1'b0;

    function automatic int count_busy();
        int c = 0;
        for (int i = 0; i < TAGS; i++) if (m_busy[i]) c++;
        return c;
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < TAGS; i++) if (!m_busy[i]) return i;
        return 0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < TAGS; i++) begin
            m_busy[i] = 1'b0; m_slot[i] = '0; m_store[i] = 1'b0;
        end
        e_dv = 1'b0; e_err = 1'b0; e_slot = '0; e_st = 1'b0; e_data = '0;
    endtask

    // One cycle: drive, check, advance model, clock.
    task automatic step(input bit cv, input bit st, input bit [SLOT_W-1:0] slot,
                        input bit mr, input bit rv, input bit [TAG_W-1:0] rt,
                        input bit [DATA_W-1:0] rd);
        bit free_ok;
        int ft;
        bit fire, hit;
        @(negedge clk);
        cl_req_valid = cv; cl_req_store = st; cl_req_slot = slot;
        cl_req_addr = $urandom; cl_req_size = SIZE_W'($urandom);
        cl_req_wdata = {$urandom, $urandom};
        mem_req_ready = mr; mem_rsp_valid = rv; mem_rsp_tag = rt; mem_rsp_data = rd;
        #1;
        free_ok = count_busy() < TAGS;
        ft = lowest_free();
        check("R2 mem_req_valid", 64'(mem_req_valid), 64'(cv && free_ok));
        check("R2 cl_req_ready", 64'(cl_req_ready), 64'(mr && free_ok));
        if (cv && free_ok) begin
            check("R3 tag", 64'(mem_req_tag), 64'(ft));
            check("R3 addr", 64'(mem_req_addr), 64'(cl_req_addr));
            check("R3 store", 64'(mem_req_store), 64'(st));
            check("R3 size", 64'(mem_req_size), 64'(cl_req_size));
            check("R3 wdata", 64'(mem_req_wdata), 64'(cl_req_wdata));
        end
        check("R5 done_valid", 64'(cl_done_valid), 64'(e_dv));
        if (e_dv) begin
            check("R6 done_slot", 64'(cl_done_slot), 64'(e_slot));
            check("R5 done_store", 64'(cl_done_store), 64'(e_st));
            check("R5 done_data", 64'(cl_done_data), 64'(e_data));
        end
        check("R8 tag_err", 64'(tag_err), 64'(e_err));
        fire = cv && mr && free_ok;
        hit  = rv && m_busy[rt];
        e_dv = hit;
        if (hit) begin
            e_slot = m_slot[rt]; e_st = m_store[rt];
            e_data = m_store[rt] ? '0 : rd;
            m_busy[rt] = 1'b0;
        end
        if (rv && !hit) e_err = 1'b1;
        if (fire) begin
            m_busy[ft] = 1'b1; m_slot[ft] = slot; m_store[ft] = st;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cl_req_valid = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check("R1 done_valid", 64'(cl_done_valid), 64'd0);
        check("R1 tag_err", 64'(tag_err), 64'd0);
        check("R1 ready", 64'(cl_req_ready), 64'd1);
        check("R1 tag", 64'(mem_req_tag), 64'd0);
    endtask

    initial begin : main
        int pick;
        void'($urandom(32'd20240611));
        do_reset();

        // R9, R2: fill every tag, then try to issue more
        for (int i = 0; i < TAGS; i++) step(1'b1, i[0], SLOT_W'(i + 3), 1'b1, 1'b0, '0, '0);
        step(1'b1, 1'b0, 5'd9, 1'b1, 1'b0, '0, '0);
        step(1'b1, 1'b0, 5'd9, 1'b0, 1'b0, '0, '0);

        // R7: response frees tag 2 while full; issue blocked this cycle, tag 2 next cycle
        step(1'b1, 1'b0, 5'd11, 1'b1, 1'b1, 2'd2, 64'hAAAA_5555_0000_1111);
        step(1'b1, 1'b0, 5'd12, 1'b1, 1'b0, '0, '0);

        // R6: out-of-order retirement (tags 3, 0, 1)
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd3, 64'h3333);
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd0, 64'h0000_0000_DEAD_0000);
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd1, 64'h1111);

        // R4: ready held low, same tag must remain offered
        step(1'b1, 1'b1, 5'd20, 1'b0, 1'b0, '0, '0);
        step(1'b1, 1'b1, 5'd20, 1'b0, 1'b0, '0, '0);
        step(1'b1, 1'b1, 5'd20, 1'b1, 1'b0, '0, '0);

        // R7: free tag 2 and allocate tag 1 in the same cycle
        step(1'b1, 1'b0, 5'd21, 1'b1, 1'b1, 2'd2, 64'h2222);
        step(1'b1, 1'b0, 5'd22, 1'b1, 1'b0, '0, '0);
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd0, 64'h4444);
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd1, 64'h5555);
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd2, 64'h6666);

        // R8: stray response for idle tag, then check stickiness
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, 2'd3, 64'h7777);
        idle();
        idle();

        // Clear error through reset, then constrained random traffic
        do_reset();
        for (int k = 0; k < 600; k++) begin
            bit rv;
            bit [TAG_W-1:0] rt;
            rv = ($urandom % 100) < 45;
            rt = TAG_W'($urandom);
            pick = $urandom % 100;
            if (pick < 97 && count_busy() > 0) begin
                for (int j = 0; j < TAGS; j++) begin
                    if (m_busy[(int'(rt) + j) % TAGS]) begin
                        rt = TAG_W'((int'(rt) + j) % TAGS);
                        break;
                    end
                end
            end else if (pick < 97) begin
                rv = 1'b0;
            end
            step(($urandom % 100) < 70, $urandom % 2, SLOT_W'($urandom),
                 ($urandom % 100) < 75, rv, rt, {$urandom, $urandom});
        end
        idle();
        idle();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule